// File: doc/BRIEF.md
# Recursive Sine Oscillator

This block produces a sampled sine wave without a lookup table. It keeps two state registers holding the two most recent values of the waveform. On every enabled cycle it forms the next value as the latest value times a fixed coefficient, minus the older value. It then shifts the state by one place and emits the new value as a signed 16-bit sample.

The coefficient is two times the cosine of the phase step per sample, so it sets the frequency. The preloaded state sets the amplitude and the starting phase. Both are elaboration-time parameters. The state is held in signed fixed point with two integer bits and thirty fraction bits.

Top module: `sine_recur_osc`

## Requirements
- R1: While `rst` is high at a rising edge, the older state register loads `INIT_Y2` (default 0) and the newer one loads `INIT_Y1` (default ≈0.0654031 in Q2.30). In the same edge `sample` clears to 0 and `sample_vld` clears to 0. Reset takes priority over `en`.
- R2: At each rising edge with `en` high, the next value is computed as y_new = COEF·y_last − y_prev. COEF is ≈1.9957178 in Q2.30, rounded to nearest. The product is rounded back to Q2.30 before the subtraction.
- R3: In that same edge, y_prev takes the old y_last and y_last takes y_new.
- R4: In that same edge, `sample` becomes y_new × 32000, truncated toward zero to an integer. From default reset, the first sample is therefore 4176.
- R5: The scaled value saturates to the range −32768..32767 instead of wrapping.
- R6: At a rising edge with `en` low, the state and `sample` hold their values.
- R7: `sample_vld` is high in exactly the cycle after a rising edge at which `en` was high and `rst` was low.
- R8: Over 1000 consecutive steps from reset, every sample is within ±2 LSB of a real-valued model of the same recurrence.
- R9: A reset in the middle of a run restarts the sequence from the initial state. The steps after it repeat the steps after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, reloads the initial state |
| en | input | 1 | Advance the oscillator by one sample |
| sample | output | 16 | Signed output sample |
| sample_vld | output | 1 | High for one cycle after each step |

## Verification
The two functions that can share a cycle are reset and a step request. The bench raises `rst` and `en` together in the middle of a run. It then checks that no valid strobe follows, that the sample is zero, and that the next steps match the reference model restarted from the initial state. Gapped enable patterns are also applied. For these, the checks are that the sample holds between steps and that the recurrence does not advance during the idle cycles.

// File: rtl/sine_recur_osc.sv
module sine_recur_osc #(
  parameter int OUT_W   = 16,
  parameter int STATE_W = 32,
  parameter int FRAC_W  = 30,
  parameter int SCALE   = 32000,
  parameter logic signed [STATE_W-1:0] COEF    = 32'sd2142885671,
  parameter logic signed [STATE_W-1:0] INIT_Y1 = 32'sd70226044,
  parameter logic signed [STATE_W-1:0] INIT_Y2 = 32'sd0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_vld
);

  localparam int PROD_W = 2 * STATE_W;
  localparam int SC_W   = STATE_W + $clog2(SCALE + 1) + 1;
  localparam int WH_W   = SC_W - FRAC_W;
  localparam logic signed [WH_W-1:0] SAT_HI = WH_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic signed [WH_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [STATE_W-1:0] y_last, y_prev, y_new;
  logic signed [PROD_W-1:0]  prod, prod_rnd;
  logic signed [SC_W-1:0]    scaled;
  logic signed [WH_W-1:0]    whole, whole_tz;
  logic signed [OUT_W-1:0]   clipped;
  logic                      frac_nz;

  assign prod     = PROD_W'(y_last) * PROD_W'(COEF);
  assign prod_rnd = prod + $signed(PROD_W'(1) << (FRAC_W - 1));
  assign y_new    = STATE_W'(prod_rnd >>> FRAC_W) - y_prev;

  assign scaled   = SC_W'(y_new) * $signed(SC_W'(SCALE));
  assign whole    = WH_W'(scaled >>> FRAC_W);
  assign frac_nz  = |scaled[FRAC_W-1:0];
  assign whole_tz = (scaled[SC_W-1] && frac_nz) ? whole + WH_W'(1) : whole;

  always_comb begin
    if (whole_tz > SAT_HI)      clipped = SAT_HI[OUT_W-1:0];
    else if (whole_tz < SAT_LO) clipped = SAT_LO[OUT_W-1:0];
    else                        clipped = whole_tz[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_last     <= INIT_Y1;
      y_prev     <= INIT_Y2;
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= en;
      if (en) begin
        y_last <= y_new;
        y_prev <= y_last;
        sample <= clipped;
      end
    end
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    $past(rst) |-> (y_last == INIT_Y1 && y_prev == INIT_Y2 && !sample_vld && sample == '0));

  assert_state_shift_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (y_prev == $past(y_last)));

  assert_sign_follows_state_R4: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && sample < 0) |-> y_last[STATE_W-1]);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sample) && $stable(y_last) && $stable(y_prev)));

  assert_valid_follows_en_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (sample_vld == $past(en)));

endmodule

// File: tb/tb_sine_recur_osc.sv
module tb_sine_recur_osc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic en_h = 1'b0;
  logic signed [15:0] sample, sample_h;
  logic sample_vld, sample_vld_h;

  int n_vec = 0;
  int n_bad = 0;
  real r1, r2, h1, h2;
  int held;
  bit done = 1'b0;

  localparam real A_REF = 1.9957178;
  localparam real Y1_REF = 0.0654031;
  localparam real HOT = 1.1;

  always #2.5 clk = ~clk;

  sine_recur_osc dut (.clk(clk), .rst(rst), .en(en), .sample(sample), .sample_vld(sample_vld));

  sine_recur_osc #(.INIT_Y1(32'sd77248648)) dut_hot (
    .clk(clk), .rst(rst), .en(en_h), .sample(sample_h), .sample_vld(sample_vld_h));

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int to_sample(real y);
    int t;
    t = $rtoi(32000.0 * y);
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic ref_step(inout real a1, inout real a2, output int s);
    real y0;
    y0 = a1 * A_REF - a2;
    a2 = a1;
    a1 = y0;
    s = to_sample(y0);
  endtask

  function automatic bit near(int a, int b);
    return (a - b <= 2) && (b - a <= 2);
  endfunction

  task automatic t_reset(bit with_en);
    @(negedge clk);
    rst = 1'b1; en = with_en;
    repeat (2) @(negedge clk);
    rst = 1'b0; en = 1'b0;
    r1 = Y1_REF; r2 = 0.0;
    h1 = Y1_REF * HOT; h2 = 0.0;
    held = 0;
    chk(sample == 0, "R1", sample, 0);
    chk(sample_vld == 1'b0, "R1", sample_vld, 0);
  endtask

  task automatic run(int n, int period, string tag);
    int e;
    for (int i = 0; i < n; i++) begin
      bit step;
      step = (i % period) == 0;
      en = step;
      @(posedge clk);
      @(negedge clk);
      if (step) begin
        ref_step(r1, r2, e);
        chk(sample_vld == 1'b1, "R7", sample_vld, 1);
        chk(near(sample, e), tag, sample, e);
        held = sample;
      end else begin
        chk(sample_vld == 1'b0, "R7", sample_vld, 0);
        chk(sample == held, "R6", sample, held);
      end
    end
    en = 1'b0;
  endtask

  task automatic t_first;
    int e;
    t_reset(1'b0);
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    en = 1'b0;
    ref_step(r1, r2, e);
    chk(sample == 4176, "R4", sample, 4176);
    chk(sample == e, "R4", sample, e);
    chk(sample_vld == 1'b1, "R7", sample_vld, 1);
    held = sample;
    @(posedge clk); @(negedge clk);
    chk(sample_vld == 1'b0, "R7", sample_vld, 0);
  endtask

  task automatic t_gapped;
    t_reset(1'b0);
    run(150, 3, "R2");
    run(90, 2, "R3");
    run(40, 7, "R6");
  endtask

  task automatic t_accuracy;
    t_reset(1'b0);
    run(1000, 1, "R8");
  endtask

  task automatic t_midreset;
    t_reset(1'b0);
    run(37, 1, "R9");
    t_reset(1'b1);
    @(posedge clk); @(negedge clk);
    chk(sample_vld == 1'b0, "R9", sample_vld, 0);
    chk(sample == 0, "R9", sample, 0);
    run(60, 1, "R9");
  endtask

  task automatic t_saturate;
    int e, hi, lo;
    t_reset(1'b0);
    hi = -40000; lo = 40000;
    for (int i = 0; i < 400; i++) begin
      en_h = 1'b1;
      @(posedge clk); @(negedge clk);
      ref_step(h1, h2, e);
      chk(near(sample_h, e), "R5", sample_h, e);
      if (sample_h > hi) hi = sample_h;
      if (sample_h < lo) lo = sample_h;
    end
    en_h = 1'b0;
    chk(hi == 32767, "R5", hi, 32767);
    chk(lo == -32768, "R5", lo, -32768);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_first();
    t_gapped();
    t_accuracy();
    t_midreset();
    t_saturate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule